// File: doc/BRIEF.md
# Host Register Port for an Asynchronous 8-bit CPU Bus

This block is the slave side of an asynchronous 8-bit parallel host bus. A host reaches the chip's internal registers and tables through a few directly addressed ports, chosen by a 3-bit port select. One port holds an index into the register space. A second port moves data to or from the register that the index names, and the index steps forward after every completed data access. The remaining port codes are inert.

The host strobes are not related to the system clock. Each strobe is combined with the active-low chip select into a command pulse, and both pulses are brought into the system clock through a two-stage synchronizer. A measuring stage counts how long each pulse stays low, how long the bus stays idle before the next pulse, and the time from one pulse start to the next. A pulse that starts too soon after the previous one is ignored. A pulse that is too short commits nothing. For some time after reset release, every access is ignored while the clocks settle.

During an accepted access the block drives a wait handshake and a ready handshake. During an accepted read it also drives the data bus. All of these are released to high impedance through enable outputs at any other time. Writes take effect on the register side only after the command pulse ends.

Top module: `host_regport`

## Requirements
- R1: An access exists only while chip select `cs_n` is low together with `rd_n` (read) or `wr_n` (write). A strobe with chip select high drives no output and changes no state.
- R2: A write is issued to the register side (`reg_we`) only after the command pulse has returned high, and never while the handshake outputs are driven.
- R3: A command pulse that is low for fewer than MIN_ACT (default 2) system clocks is not committed. A write through it changes nothing, and the index does not advance.
- R4: A pulse that starts fewer than MIN_INH (default 4) idle clocks after the previous pulse ended is ignored entirely. Exactly MIN_INH idle clocks is accepted.
- R5: A pulse that starts fewer than MIN_CYC (default 6) clocks after the previous pulse started is ignored entirely.
- R6: For LOCK_CYC (default 40000) system clocks after reset release, every access is ignored.
- R7: Port code 0 is the index port. A write loads the index, and a read returns the index. The index is 0 after reset.
- R8: Port code 1 is the data port. A write stores the bus byte at the index, and a read returns the register at the index. After either, the index increments by one and wraps from its maximum to 0.
- R9: Port codes 2 to 7 ignore writes and return 0x00 on reads.
- R10: The data-bus enable `bus_doe` is high only during an accepted read. The handshake enable `hs_oe` is high only during an accepted access. Both are low in reset and when idle.
- R11: On a data-port read, `wait_n` is low (`ready_n` high) for exactly one clock after `hs_oe` rises, then `wait_n` goes high and `ready_n` goes low with the read data on `bus_dout`. Index-port reads, other-port reads and writes report ready as soon as `hs_oe` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| port_sel | input | 3 | Port select |
| bus_din | input | 8 | Data bus input from pad |
| bus_dout | output | 8 | Data bus output to pad |
| bus_doe | output | 1 | Data bus output enable |
| wait_n | output | 1 | Wait handshake value (low = wait) |
| ready_n | output | 1 | Ready handshake value (low = ready) |
| hs_oe | output | 1 | Output enable for both handshake pads |
| reg_addr | output | AW | Register-side address |
| reg_wdata | output | 8 | Register-side write data |
| reg_we | output | 1 | Register-side write strobe, one clock |
| reg_re | output | 1 | Register-side read strobe, one clock |
| reg_rdata | input | 8 | Register-side read data, valid the clock after `reg_re` |

## Verification
Two events can land in the same clock edge. The first is the end of one pulse, where the index is committed and advanced. The second is the start of the next pulse, which the idle and cycle checks must judge against that same end. The bench provokes this by running the next pulse at idle gaps of exactly three and four clocks, and after a one-clock pulse followed by four idle clocks. Each outcome is judged through the index port: the index value read back shows whether the later write was taken.

The second coincidence is a data-port write committing while the index advances on the same edge. Reading back through both ports shows whether the store used the index from before the step.

// File: rtl/host_regport_pkg.sv
package host_regport_pkg;

  localparam logic [2:0] PORT_INDEX = 3'd0;
  localparam logic [2:0] PORT_DATA  = 3'd1;

  typedef struct packed {
    logic       live;
    logic       rd;
    logic [2:0] port;
  } acc_t;

  // A new pulse may begin once the bus has idled long enough and a full
  // command cycle has elapsed since the previous pulse began.
  function automatic logic gap_ok(input int unsigned idle_clk,
                                  input int unsigned since_start,
                                  input int unsigned min_inh,
                                  input int unsigned min_cyc);
    return (idle_clk >= min_inh) && (since_start >= min_cyc);
  endfunction

  function automatic logic width_ok(input int unsigned low_clk,
                                    input int unsigned min_act);
    return low_clk >= min_act;
  endfunction

endpackage

// File: rtl/host_regport_sync.sv
module host_regport_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '1;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/host_regport_pulse.sv
module host_regport_pulse
  import host_regport_pkg::*;
#(
  parameter int MIN_ACT = 2,
  parameter int MIN_INH = 4,
  parameter int MIN_CYC = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rcmd_s,
  input  logic wcmd_s,
  output logic fall_ev,
  output logic rise_ev,
  output logic rd_kind,
  output logic start_ok,
  output logic wide_ok
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_CYC);

  logic          cmd_s, cmd_d;
  logic [CW-1:0] act_cnt, idle_cnt, cyc_cnt;

  assign cmd_s   = rcmd_s & wcmd_s;
  assign fall_ev = cmd_d & ~cmd_s;
  assign rise_ev = ~cmd_d & cmd_s;
  assign rd_kind = ~rcmd_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_d    <= 1'b1;
      act_cnt  <= '0;
      idle_cnt <= SAT;
      cyc_cnt  <= SAT;
    end else begin
      cmd_d <= cmd_s;
      if (fall_ev)                       act_cnt <= CW'(1);
      else if (!cmd_s && act_cnt < SAT)  act_cnt <= act_cnt + 1'b1;
      if (rise_ev)                       idle_cnt <= CW'(1);
      else if (cmd_s && idle_cnt < SAT)  idle_cnt <= idle_cnt + 1'b1;
      if (fall_ev)                       cyc_cnt <= CW'(1);
      else if (cyc_cnt < SAT)            cyc_cnt <= cyc_cnt + 1'b1;
    end
  end

  assign start_ok = gap_ok(32'(idle_cnt), 32'(cyc_cnt), MIN_INH, MIN_CYC);
  assign wide_ok  = width_ok(32'(act_cnt), MIN_ACT);
endmodule

// File: rtl/host_regport_lock.sv
module host_regport_lock #(
  parameter int LOCK_CYC = 40000
) (
  input  logic clk,
  input  logic rst_n,
  output logic locked
);
  localparam int LW = $clog2(LOCK_CYC + 2);
  localparam logic [LW-1:0] LIMIT = LW'(LOCK_CYC);

  logic [LW-1:0] cnt;

  assign locked = (cnt != LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (locked) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/host_regport.sv
module host_regport
  import host_regport_pkg::*;
#(
  parameter int AW       = 8,
  parameter int MIN_ACT  = 2,
  parameter int MIN_INH  = 4,
  parameter int MIN_CYC  = 6,
  parameter int LOCK_CYC = 40000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [2:0]    port_sel,
  input  logic [7:0]    bus_din,
  output logic [7:0]    bus_dout,
  output logic          bus_doe,
  output logic          wait_n,
  output logic          ready_n,
  output logic          hs_oe,
  output logic [AW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_we,
  output logic          reg_re,
  input  logic [7:0]    reg_rdata
);
  localparam int DW = 8;

  logic [1:0]    cmd_raw, cmd_s;
  logic          fall_ev, rise_ev, rd_kind, start_ok, wide_ok, locked;
  logic          accept, commit, data_rd;
  logic [DW-1:0] d1, d2, dhold;
  acc_t          acc;
  logic [AW-1:0] idx, waddr_q;
  logic [DW-1:0] rdata_q, wdata_q;
  logic          rdy, re_q, we_q;

  function automatic logic [DW-1:0] direct_value(input logic [2:0] p,
                                                 input logic [AW-1:0] i);
    return (p == PORT_INDEX) ? DW'(i) : '0;
  endfunction

  assign cmd_raw = {cs_n | rd_n, cs_n | wr_n};

  host_regport_sync #(.W(2), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cmd_raw), .q(cmd_s)
  );

  host_regport_pulse #(.MIN_ACT(MIN_ACT), .MIN_INH(MIN_INH), .MIN_CYC(MIN_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .rcmd_s(cmd_s[1]), .wcmd_s(cmd_s[0]),
    .fall_ev(fall_ev), .rise_ev(rise_ev), .rd_kind(rd_kind),
    .start_ok(start_ok), .wide_ok(wide_ok)
  );

  host_regport_lock #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .locked(locked)
  );

  assign accept  = fall_ev & start_ok & ~locked;
  assign commit  = rise_ev & acc.live & wide_ok;
  assign data_rd = rd_kind & (port_sel == PORT_DATA);

  // Bus data pipeline aligned with the strobe synchronizer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1    <= '0;
      d2    <= '0;
      dhold <= '0;
    end else begin
      d1 <= bus_din;
      d2 <= d1;
      if (!cmd_s[0]) dhold <= d2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc     <= '0;
      idx     <= '0;
      waddr_q <= '0;
      rdata_q <= '0;
      wdata_q <= '0;
      rdy     <= 1'b0;
      re_q    <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      re_q <= 1'b0;
      we_q <= 1'b0;
      if (re_q && acc.live) begin
        rdata_q <= reg_rdata;
        rdy     <= 1'b1;
      end
      if (accept) begin
        acc     <= '{live: 1'b1, rd: rd_kind, port: port_sel};
        rdy     <= ~data_rd;
        re_q    <= data_rd;
        rdata_q <= direct_value(port_sel, idx);
      end else if (rise_ev) begin
        acc.live <= 1'b0;
        rdy      <= 1'b0;
      end
      if (commit) begin
        if (acc.port == PORT_INDEX && !acc.rd) idx <= dhold[AW-1:0];
        if (acc.port == PORT_DATA) begin
          if (!acc.rd) begin
            we_q    <= 1'b1;
            waddr_q <= idx;
            wdata_q <= dhold;
          end
          idx <= idx + 1'b1;
        end
      end
    end
  end

  assign reg_addr  = we_q ? waddr_q : idx;
  assign reg_wdata = wdata_q;
  assign reg_we    = we_q;
  assign reg_re    = re_q;
  assign hs_oe     = acc.live;
  assign bus_doe   = acc.live & acc.rd;
  assign bus_dout  = rdata_q;
  assign wait_n    = rdy;
  assign ready_n   = ~rdy;
endmodule

// File: rtl/host_regport_chk.sv
module host_regport_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hs_oe,
  input logic       bus_doe,
  input logic       wait_n,
  input logic       reg_we,
  input logic       reg_re,
  input logic [7:0] bus_dout,
  input logic       locked,
  input logic       fall_ev
);
  AST_DOE_WITHIN_HS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> hs_oe); // R10

  AST_LOCK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!hs_oe && !reg_we && !reg_re)); // R6

  AST_WAIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_oe && !wait_n) |=> (wait_n || !hs_oe)); // R11

  AST_HS_FROM_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_oe) |-> $past(fall_ev)); // R1

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we); // R8

  AST_RE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re); // R8

  AST_WE_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !hs_oe); // R2

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_doe && $past(bus_doe) && wait_n && $past(wait_n)) |-> $stable(bus_dout)); // R11
endmodule

bind host_regport host_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_oe(hs_oe), .bus_doe(bus_doe),
  .wait_n(wait_n), .reg_we(reg_we), .reg_re(reg_re), .bus_dout(bus_dout),
  .locked(locked), .fall_ev(fall_ev)
);

// File: tb/tb_host_regport.sv
module tb_host_regport;
  localparam int LOCK = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] port_sel = '0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout, reg_wdata, reg_rdata;
  logic [7:0] reg_addr;
  logic       bus_doe, wait_n, ready_n, hs_oe, reg_we, reg_re;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] exp_idx = '0;
  int n_chk = 0, n_fail = 0, we_cnt = 0;
  int prev_act = 100, prev_gap = 100;
  bit in_lock = 1'b0;

  always #10 clk = ~clk;

  host_regport #(.LOCK_CYC(LOCK)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .port_sel(port_sel), .bus_din(bus_din), .bus_dout(bus_dout),
    .bus_doe(bus_doe), .wait_n(wait_n), .ready_n(ready_n), .hs_oe(hs_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  // Register file stand-in on the register side.
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) begin
    mem[reg_addr] <= reg_wdata;
    we_cnt <= we_cnt + 1;
  end

  function automatic bit f_accept(input int pa, input int pg);
    return (pg >= 4) && (pa + pg >= 6);
  endfunction

  function automatic logic [7:0] f_read(input logic [2:0] p);
    if (p == 3'd0) return exp_idx;
    if (p == 3'd1) return exp_mem[exp_idx];
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] want);
    n_chk++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, want);
    end
  endtask

  task automatic apply(input bit rd, input logic [2:0] p, input logic [7:0] wd);
    if (p == 3'd0 && !rd) exp_idx = wd;
    if (p == 3'd1) begin
      if (!rd) exp_mem[exp_idx] = wd;
      exp_idx = exp_idx + 8'd1;
    end
  endtask

  task automatic op(input bit rd, input logic [2:0] p, input logic [7:0] wd,
                    input int act, input int gap, input string req);
    bit acc;
    logic [7:0] expv;
    logic sb_oe;
    logic [7:0] sb_d;
    acc  = f_accept(prev_act, prev_gap) && !in_lock;
    expv = f_read(p);
    @(negedge clk);
    port_sel = p; bus_din = wd; cs_n = 1'b0;
    if (rd) rd_n = 1'b0; else wr_n = 1'b0;
    repeat (act) @(negedge clk);
    sb_oe = bus_doe; sb_d = bus_dout;
    cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
    repeat (gap - 1) @(negedge clk);
    if (rd && act >= 4) begin
      if (acc) chk(req, 32'({sb_oe, sb_d}), 32'({1'b1, expv}));
      else     chk(req, 32'(sb_oe), 32'd0);
    end
    if (acc && act >= 2) apply(rd, p, wd);
    prev_act = act;
    prev_gap = gap;
  endtask

  task automatic rd_chk(input logic [2:0] p, input string req);
    op(1'b1, p, 8'h00, 5, 6, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'((i * 37 + 5) & 255);
      exp_mem[i] = 8'((i * 37 + 5) & 255);
    end
    void'($urandom(2024));
    repeat (5) @(negedge clk);
    chk("R10 reset hs_oe", 32'(hs_oe), 0);
    chk("R10 reset bus_doe", 32'(bus_doe), 0);
    chk("R2 reset reg_we", 32'(reg_we), 0);
    rst_n = 1'b1;

    // R6: lockout window
    in_lock = 1'b1;
    op(1'b1, 3'd0, 8'h00, 6, 6, "R6 read in lockout");
    op(1'b0, 3'd0, 8'h55, 4, 6, "R6 write in lockout");
    repeat (LOCK) @(negedge clk);
    in_lock = 1'b0;
    prev_gap = 100;
    rd_chk(3'd0, "R6 index untouched by lockout write");

    // R7 index port
    op(1'b0, 3'd0, 8'h10, 3, 6, "R7");
    rd_chk(3'd0, "R7 index readback");

    // R8 data port with auto-increment
    op(1'b0, 3'd1, 8'hA5, 3, 6, "R8");
    op(1'b0, 3'd1, 8'h3C, 3, 6, "R8");
    rd_chk(3'd0, "R8 index after two writes");
    op(1'b0, 3'd0, 8'h10, 3, 6, "R8");
    rd_chk(3'd1, "R8 first data");
    rd_chk(3'd1, "R8 second data");
    rd_chk(3'd0, "R8 index after reads");

    // R8 wrap
    op(1'b0, 3'd0, 8'hFF, 3, 6, "R8");
    op(1'b0, 3'd1, 8'h77, 3, 6, "R8");
    rd_chk(3'd0, "R8 index wrapped to 0");
    op(1'b0, 3'd0, 8'hFF, 3, 6, "R8");
    rd_chk(3'd1, "R8 data at top");

    // R9 other ports
    op(1'b0, 3'd0, 8'h40, 3, 6, "R9");
    op(1'b0, 3'd5, 8'h99, 3, 6, "R9");
    rd_chk(3'd5, "R9 read of port 5");
    rd_chk(3'd0, "R9 index unchanged");
    rd_chk(3'd1, "R9 data unchanged");

    // R3 too-short write
    op(1'b0, 3'd0, 8'h20, 3, 6, "R3");
    op(1'b0, 3'd1, 8'hEE, 1, 6, "R3");
    rd_chk(3'd0, "R3 index not advanced");
    rd_chk(3'd1, "R3 register not written");

    // R4 inhibit boundary
    op(1'b0, 3'd0, 8'h30, 3, 3, "R4");
    op(1'b0, 3'd0, 8'h44, 3, 6, "R4 rejected after 3 idle");
    rd_chk(3'd0, "R4 index after short gap");
    op(1'b0, 3'd0, 8'h31, 3, 4, "R4");
    op(1'b0, 3'd0, 8'h45, 3, 6, "R4 accepted after 4 idle");
    rd_chk(3'd0, "R4 index after exact gap");

    // R5 cycle time: 1 low + 4 idle = 5 clocks
    op(1'b1, 3'd0, 8'h00, 1, 4, "R5");
    op(1'b0, 3'd0, 8'h66, 3, 6, "R5 rejected short cycle");
    rd_chk(3'd0, "R5 index after short cycle");

    // R1 strobe without chip select
    @(negedge clk);
    port_sel = 3'd0; bus_din = 8'h66; wr_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1 no handshake without cs", 32'(hs_oe), 0);
    wr_n = 1'b1; rd_n = 1'b0;
    repeat (6) @(negedge clk);
    chk("R1 no bus drive without cs", 32'(bus_doe), 0);
    rd_n = 1'b1;
    repeat (6) @(negedge clk);
    prev_gap = 100;
    rd_chk(3'd0, "R1 index unchanged");

    // R11/R10 cycle-exact data-port read
    begin
      logic [7:0] expv;
      expv = exp_mem[exp_idx];
      @(negedge clk);
      port_sel = 3'd1; cs_n = 1'b0; rd_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 hs_oe on", 32'(hs_oe), 1);
      chk("R10 bus_doe on read", 32'(bus_doe), 1);
      chk("R11 wait low", 32'({wait_n, ready_n}), 32'h1);
      @(negedge clk);
      chk("R11 ready after one clock", 32'({wait_n, ready_n}), 32'h2);
      chk("R11 read data", 32'(bus_dout), 32'(expv));
      repeat (2) @(negedge clk);
      cs_n = 1'b1; rd_n = 1'b1;
      repeat (7) @(negedge clk);
      chk("R10 released after read", 32'({hs_oe, bus_doe}), 0);
      apply(1'b1, 3'd1, 8'h00);
    end

    // R2/R11/R10 long write
    begin
      int w0;
      w0 = we_cnt;
      @(negedge clk);
      port_sel = 3'd1; bus_din = 8'h5A; cs_n = 1'b0; wr_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R11 write ready at once", 32'({hs_oe, bus_doe, ready_n}), 32'h4);
      repeat (5) @(negedge clk);
      chk("R2 no write during pulse", 32'(we_cnt), 32'(w0));
      cs_n = 1'b1; wr_n = 1'b1;
      repeat (6) @(negedge clk);
      chk("R2 write after pulse end", 32'(we_cnt), 32'(w0 + 1));
      apply(1'b0, 3'd1, 8'h5A);
      prev_act = 8; prev_gap = 100;
    end

    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [2:0] p;
      int sel;
      sel = $urandom_range(0, 2);
      p = (sel == 0) ? 3'd0 : (sel == 1) ? 3'd1 : 3'd6;
      op(1'($urandom_range(0, 1)), p, 8'($urandom_range(0, 255)),
         $urandom_range(1, 5), $urandom_range(2, 6), "R8 random");
    end
    repeat (10) @(negedge clk);
    prev_gap = 100;
    rd_chk(3'd0, "R7 final index");
    chk("R10 idle release", 32'({hs_oe, bus_doe}), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule